// File: doc/BRIEF.md
# NAND Flash Register-Window Bridge

This block connects a byte-wide host register bus to the pins of a raw NAND flash device. Each host access carries a 32-bit byte address. The 256-byte page at address 0 belongs to a neighbouring system control unit. The page at address 0x100 holds this block's configuration: an enable bit and a 32-bit base address. When the block is enabled, it answers a 256-byte data window at that base.

Inside the window the host drives the flash pins by hand. A mode byte holds the command latch, address latch, chip select and write protect levels, and a two-bit field in it asks an external ECC unit to clear, run or enter its read phase. Data bytes pass straight between the host and the flash I/O bus, and each one comes with a single-cycle read or write strobe. A status register, a mask register and a global enable bit in the mask produce an interrupt line. Flash timing, the ECC arithmetic and the flash array all sit outside this block.

Top module: `nand_window_bridge`

## Requirements
- R1: After reset, `irq`, `fl_cle`, `fl_ale`, `fl_wp`, `fl_re`, `fl_we`, `ecc_clear`, `ecc_enable` and `ecc_read_phase` are 0, `fl_ce_n` is 1, and the configuration command byte reads 0.
- R2: A write to address 0x104 sets the window enable to bit 1 of the data. A read of 0x104 returns 0x02 when the window is enabled and 0x00 when it is not.
- R3: Byte k of the 32-bit window base, with k from 0 to 3 and byte 0 the least significant, is written and read at address 0x110+k.
- R4: A window access hits when address bits 31:8 equal base bits 31:8 and the window is enabled. Addresses whose bits 31:8 are 0 or 1 are never window accesses, even when the base matches them.
- R5: A write to window offset 0, 1, 2 or 3 puts the data byte on `fl_dout`, raises `fl_we` for exactly one cycle and sets bit 0 of the interrupt status.
- R6: A read of window offset 0 to 3 raises `fl_re` for exactly one cycle and returns the value of `fl_din`.
- R7: The mode byte at window offset 0x04 is readable and writable. Bit 0 drives `fl_cle`, bit 1 drives `fl_ale`, bit 7 drives `fl_wp`, and bit 4 set drives `fl_ce_n` low.
- R8: Mode bits 6:5 select the ECC action. When the mode byte is written with value 3 in this field, `ecc_clear` pulses for one cycle. With value 1, `ecc_clear` and `ecc_enable` both pulse. Value 0 gives no pulse. `ecc_read_phase` is high for as long as the stored field equals 2.
- R9: A read of window offset 0x05 always returns 0x14.
- R10: The interrupt status (window offset 0x06) and the interrupt mask (offset 0x07) are plain read/write bytes. `irq` is high exactly when mask bit 7 is 1 and the bitwise AND of mask and status is nonzero.
- R11: An access that misses pages 0 and 1 and misses the enabled window reads 0 and changes no flash pin. Unmapped offsets in the configuration page and in the window also read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle after the access |
| fl_din | input | 8 | Flash I/O bus toward the host |
| fl_dout | output | 8 | Flash I/O bus toward the flash |
| fl_cle | output | 1 | Command latch enable |
| fl_ale | output | 1 | Address latch enable |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_wp | output | 1 | Write protect level (mode bit 7) |
| fl_re | output | 1 | One-cycle read strobe |
| fl_we | output | 1 | One-cycle write strobe |
| ecc_clear | output | 1 | One-cycle ECC accumulator clear |
| ecc_enable | output | 1 | One-cycle ECC start |
| ecc_read_phase | output | 1 | ECC read phase level |
| irq | output | 1 | Interrupt request |

## Verification
Every result is registered once at the clock edge that samples the access. Read data, the strobes, the ECC pulses, the pin levels and `irq` are therefore all due in the cycle that follows that edge. The driver changes inputs on falling edges, and the monitor pops each expected read byte from the queue at the next falling edge, half a cycle after the result was registered. Pulse checks look at the same falling edge and then one cycle later, to confirm the strobe has dropped again.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

    localparam int unsigned PAGE_W   = 8;
    localparam logic [7:0]  CFG_CMD  = 8'h04;
    localparam logic [7:0]  CFG_BASE = 8'h10;
    localparam logic [7:0]  WIN_MODE = 8'h04;
    localparam logic [7:0]  WIN_STAT = 8'h05;
    localparam logic [7:0]  WIN_ISR  = 8'h06;
    localparam logic [7:0]  WIN_IMR  = 8'h07;
    localparam logic [7:0]  STAT_VAL = 8'h14;

    typedef enum logic [1:0] {
        ECC_IDLE  = 2'd0,
        ECC_START = 2'd1,
        ECC_READ  = 2'd2,
        ECC_CLEAR = 2'd3
    } ecc_act_e;

    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] isr;
        logic [7:0] imr;
        logic [7:0] dout;
        logic       we;
        logic       re;
        logic       ecc_clr;
        logic       ecc_en;
    } port_st_t;

endpackage

// File: rtl/nwb_decode.sv
module nwb_decode #(
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned UP_W  = ADDR_W - nwb_pkg::PAGE_W
) (
    input  logic              sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              win_en,
    input  logic [UP_W-1:0]   win_page,
    output logic              sys_hit,
    output logic              cfg_hit,
    output logic              win_hit,
    output logic [7:0]        offset
);
    logic [UP_W-1:0] page;

    always_comb begin
        page    = addr[ADDR_W-1:nwb_pkg::PAGE_W];
        offset  = addr[nwb_pkg::PAGE_W-1:0];
        sys_hit = sel && (page == UP_W'(0));
        cfg_hit = sel && (page == UP_W'(1));
        // fixed pages win over the relocatable window
        win_hit = sel && !sys_hit && !cfg_hit && win_en && (page == win_page);
    end
endmodule

// File: rtl/nwb_cfg.sv
module nwb_cfg #(
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned NBYTE = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sel,
    input  logic              wr,
    input  logic [7:0]        off,
    input  logic [7:0]        wdata,
    output logic              win_en,
    output logic [ADDR_W-1:0] win_base,
    output logic [7:0]        rd_data
);
    import nwb_pkg::*;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rd_data = 8'h00;
        if (cfg_sel && wr && off == CFG_CMD) begin
            st_d.en = wdata[1];
        end
        if (off == CFG_CMD) begin
            rd_data = {6'b0, st_q.en, 1'b0};
        end
        for (int i = 0; i < NBYTE; i++) begin
            if (off == CFG_BASE + 8'(i)) begin
                rd_data = st_q.base[i*8 +: 8];
                if (cfg_sel && wr) begin
                    st_d.base[i*8 +: 8] = wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_en   = st_q.en;
    assign win_base = st_q.base;

    // R2
    en_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.en) |-> $past(cfg_sel && wr));

    // R3
    base_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.base) |-> $past(cfg_sel && wr));
endmodule

// File: rtl/nwb_flash_port.sv
module nwb_flash_port (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       win_sel,
    input  logic       wr,
    input  logic [7:0] off,
    input  logic [7:0] wdata,
    input  logic [7:0] fl_din,
    output logic [7:0] rd_data,
    output logic [7:0] fl_dout,
    output logic       fl_cle,
    output logic       fl_ale,
    output logic       fl_ce_n,
    output logic       fl_wp,
    output logic       fl_re,
    output logic       fl_we,
    output logic       ecc_clear,
    output logic       ecc_enable,
    output logic       ecc_read_phase,
    output logic       irq
);
    import nwb_pkg::*;

    port_st_t st_d, st_q;
    logic     data_off;
    ecc_act_e act_w;

    always_comb begin
        data_off   = (off[7:2] == 6'd0);
        act_w      = ecc_act_e'(wdata[6:5]);
        st_d       = st_q;
        st_d.we    = 1'b0;
        st_d.re    = 1'b0;
        st_d.ecc_clr = 1'b0;
        st_d.ecc_en  = 1'b0;
        if (win_sel && wr) begin
            if (data_off) begin
                st_d.dout   = wdata;
                st_d.we     = 1'b1;
                st_d.isr[0] = 1'b1;
            end else begin
                unique case (off)
                    WIN_MODE: begin
                        st_d.mode = wdata;
                        if (act_w == ECC_CLEAR || act_w == ECC_START) begin
                            st_d.ecc_clr = 1'b1;
                        end
                        st_d.ecc_en = (act_w == ECC_START);
                    end
                    WIN_ISR: st_d.isr = wdata;
                    WIN_IMR: st_d.imr = wdata;
                    default: ;
                endcase
            end
        end else if (win_sel && data_off) begin
            st_d.re = 1'b1;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        if (data_off) begin
            rd_data = fl_din;
        end else begin
            unique case (off)
                WIN_MODE: rd_data = st_q.mode;
                WIN_STAT: rd_data = STAT_VAL;
                WIN_ISR:  rd_data = st_q.isr;
                WIN_IMR:  rd_data = st_q.imr;
                default:  rd_data = 8'h00;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fl_dout        = st_q.dout;
    assign fl_cle         = st_q.mode[0];
    assign fl_ale         = st_q.mode[1];
    assign fl_ce_n        = ~st_q.mode[4];
    assign fl_wp          = st_q.mode[7];
    assign fl_re          = st_q.re;
    assign fl_we          = st_q.we;
    assign ecc_clear      = st_q.ecc_clr;
    assign ecc_enable     = st_q.ecc_en;
    assign ecc_read_phase = (ecc_act_e'(st_q.mode[6:5]) == ECC_READ);
    assign irq            = st_q.imr[7] && |(st_q.imr & st_q.isr);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> st_q.imr[7]);

    // R8
    ecc_start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_enable |-> ecc_clear);

    // R5
    isr_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.isr[0]) |-> $past(win_sel && wr));

    // R7
    mode_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.mode) |-> $past(win_sel && wr && off == WIN_MODE));
endmodule

// File: rtl/nand_window_bridge.sv
module nand_window_bridge #(
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned UP_W  = ADDR_W - nwb_pkg::PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        fl_din,
    output logic [7:0]        fl_dout,
    output logic              fl_cle,
    output logic              fl_ale,
    output logic              fl_ce_n,
    output logic              fl_wp,
    output logic              fl_re,
    output logic              fl_we,
    output logic              ecc_clear,
    output logic              ecc_enable,
    output logic              ecc_read_phase,
    output logic              irq
);
    logic              sys_hit, cfg_hit, win_hit;
    logic [7:0]        offset;
    logic              win_en;
    logic [ADDR_W-1:0] win_base;
    logic [7:0]        cfg_rd, win_rd;
    logic [7:0]        rdata_d, rdata_q;

    nwb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel      (bus_sel),
        .addr     (bus_addr),
        .win_en   (win_en),
        .win_page (win_base[ADDR_W-1:nwb_pkg::PAGE_W]),
        .sys_hit  (sys_hit),
        .cfg_hit  (cfg_hit),
        .win_hit  (win_hit),
        .offset   (offset)
    );

    nwb_cfg #(.ADDR_W(ADDR_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_sel  (cfg_hit),
        .wr       (bus_wr),
        .off      (offset),
        .wdata    (bus_wdata),
        .win_en   (win_en),
        .win_base (win_base),
        .rd_data  (cfg_rd)
    );

    nwb_flash_port u_port (
        .clk            (clk),
        .rst_n          (rst_n),
        .win_sel        (win_hit),
        .wr             (bus_wr),
        .off            (offset),
        .wdata          (bus_wdata),
        .fl_din         (fl_din),
        .rd_data        (win_rd),
        .fl_dout        (fl_dout),
        .fl_cle         (fl_cle),
        .fl_ale         (fl_ale),
        .fl_ce_n        (fl_ce_n),
        .fl_wp          (fl_wp),
        .fl_re          (fl_re),
        .fl_we          (fl_we),
        .ecc_clear      (ecc_clear),
        .ecc_enable     (ecc_enable),
        .ecc_read_phase (ecc_read_phase),
        .irq            (irq)
    );

    always_comb begin
        rdata_d = 8'h00;
        if (!bus_wr) begin
            if (cfg_hit) begin
                rdata_d = cfg_rd;
            end else if (win_hit) begin
                rdata_d = win_rd;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= 8'h00;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign bus_rdata = rdata_q;

    // R4
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_hit, cfg_hit, win_hit}));

    // R5
    we_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> $past(bus_sel && bus_wr));

    // R6
    re_from_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_re |-> $past(bus_sel && !bus_wr));

    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_re && fl_we));
endmodule

// File: tb/sim_nand_window_bridge.sv
module sim_nand_window_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  fl_din = 8'h00;
    logic [7:0]  fl_dout;
    logic fl_cle, fl_ale, fl_ce_n, fl_wp, fl_re, fl_we;
    logic ecc_clear, ecc_enable, ecc_read_phase, irq;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       rd_pend = 1'b0;
    logic       done = 1'b0;

    localparam logic [31:0] WB = 32'h0012_3400;

    always #5 clk = ~clk;

    nand_window_bridge u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fl_din(fl_din), .fl_dout(fl_dout), .fl_cle(fl_cle), .fl_ale(fl_ale),
        .fl_ce_n(fl_ce_n), .fl_wp(fl_wp), .fl_re(fl_re), .fl_we(fl_we),
        .ecc_clear(ecc_clear), .ecc_enable(ecc_enable),
        .ecc_read_phase(ecc_read_phase), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [31:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [7:0] d);
        access(1'b1, a, d);
    endtask

    task automatic rd(input logic [31:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        access(1'b0, a, 8'h00);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    always @(posedge clk) rd_pend <= bus_sel && !bus_wr;

    // monitor: read byte due one edge after the access
    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                chk("scoreboard underflow", 1, 0);
            end else begin
                chk(tag_q.pop_front(), {24'h0, bus_rdata}, {24'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        for (int i = 0; i < 5000; i++) @(posedge clk);
        if (!done) begin
            chk("watchdog expired", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 ce_n", fl_ce_n, 1);
        chk("R1 pins", {fl_cle, fl_ale, fl_wp, fl_re, fl_we}, 0);
        chk("R1 ecc", {ecc_clear, ecc_enable, ecc_read_phase}, 0);
        rd(32'h104, 8'h00, "R1 cmd reads 0");

        // R3 base bytes
        wr(32'h110, WB[7:0]); wr(32'h111, WB[15:8]);
        wr(32'h112, WB[23:16]); wr(32'h113, WB[31:24]);
        rd(32'h111, 8'h34, "R3 base byte1");
        rd(32'h112, 8'h12, "R3 base byte2");

        // R11 window disabled: no effect
        wr(WB + 32'h04, 8'h10);
        chk("R11 ce_n while disabled", fl_ce_n, 1);
        rd(WB + 32'h05, 8'h00, "R11 disabled read");

        // R2 enable bit
        wr(32'h104, 8'hFD);
        rd(32'h104, 8'h00, "R2 bit1 clear");
        wr(32'h104, 8'h02);
        rd(32'h104, 8'h02, "R2 enabled");

        rd(WB + 32'h05, 8'h14, "R9 status");
        rd(WB + 32'h20, 8'h00, "R11 unmapped window offset");

        // R7 mode pins
        wr(WB + 32'h04, 8'h93);
        chk("R7 pins", {fl_cle, fl_ale, fl_ce_n, fl_wp}, 4'b1101);
        chk("R8 field 0 no pulse", {ecc_clear, ecc_enable, ecc_read_phase}, 0);
        rd(WB + 32'h04, 8'h93, "R7 mode readback");

        // R8 ECC actions
        wr(WB + 32'h04, 8'h70);
        chk("R8 clear pulse", {ecc_clear, ecc_enable}, 2'b10);
        idle();
        chk("R8 clear drops", {ecc_clear, ecc_enable}, 2'b00);
        wr(WB + 32'h04, 8'h30);
        chk("R8 start pulse", {ecc_clear, ecc_enable}, 2'b11);
        idle();
        chk("R8 start drops", {ecc_clear, ecc_enable}, 2'b00);
        wr(WB + 32'h04, 8'h50);
        chk("R8 read phase", {ecc_clear, ecc_enable, ecc_read_phase}, 3'b001);
        idle();
        chk("R8 read phase held", ecc_read_phase, 1);
        wr(WB + 32'h04, 8'h10);
        chk("R8 read phase off", ecc_read_phase, 0);

        // R5 data write
        wr(WB + 32'h02, 8'hA5);
        chk("R5 dout", fl_dout, 8'hA5);
        chk("R5 we/re", {fl_we, fl_re}, 2'b10);
        idle();
        chk("R5 we one cycle", fl_we, 0);
        rd(WB + 32'h06, 8'h01, "R5 isr bit0");
        chk("R10 irq masked", irq, 0);

        // R10 interrupt gating
        wr(WB + 32'h07, 8'h01);
        chk("R10 no global enable", irq, 0);
        wr(WB + 32'h07, 8'h81);
        chk("R10 enabled", irq, 1);
        wr(WB + 32'h06, 8'h00);
        chk("R10 status cleared", irq, 0);
        wr(WB + 32'h06, 8'h02);
        chk("R10 mismatched bit", irq, 0);
        wr(WB + 32'h07, 8'h82);
        chk("R10 matched bit", irq, 1);
        rd(WB + 32'h07, 8'h82, "R10 mask readback");

        // R6 data read
        fl_din = 8'h3C;
        rd(WB + 32'h03, 8'h3C, "R6 read data");
        chk("R6 re/we", {fl_re, fl_we}, 2'b10);
        idle();
        chk("R6 re one cycle", fl_re, 0);

        // R11 miss and page 0
        wr(32'h0055_5500, 8'h77);
        chk("R11 miss no we", fl_we, 0);
        chk("R11 miss dout kept", fl_dout, 8'hA5);
        rd(32'h0055_5500, 8'h00, "R11 miss read");
        wr(32'h0000_0004, 8'h00);
        chk("R11 page0 keeps ce", fl_ce_n, 0);

        // R4 config page wins over a window placed on it
        wr(32'h111, 8'h01); wr(32'h112, 8'h00);
        rd(32'h105, 8'h00, "R4 cfg page precedence");
        wr(32'h104, 8'h02);
        chk("R4 no window write", fl_we, 0);
        idle();
        chk("R11 scoreboard empty", exp_q.size(), 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule